// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting slow timebase ticks. The ticks arrive as single-cycle strobes, one per millisecond, from a low-power oscillator that runs independently of the processor clock. They are already brought into the block's clock domain before they reach the block. While the watchdog is enabled, software must pulse the restart strobe before the selected number of ticks has passed. If it does not, the block emits a one-cycle reset request. The block keeps counting for as long as ticks arrive and it is enabled, whatever power state the rest of the system is in.

Window mode adds a closed interval at the start of each period. A restart inside that interval is treated as a fault, just like a timeout. This catches code that is stuck in a loop which restarts the watchdog constantly.

Settings are written through a small register port. A configuration write is only accepted during a short unlock interval, which opens when the key value is written. A sticky lock input freezes all settings until the next reset.

Top module: `win_wdt`

## Requirements
- R1: After reset, `rst_req` is 0, the watchdog is disabled, and the mode, period code and window code all read 0.
- R2: A write of 0xD8 to address 0 unlocks the configuration. A configuration write to address 1 or address 2 is accepted only in the 4 clock cycles that follow the key write. Writes made without the key, writes after a wrong key value, and writes made later than those 4 cycles leave the settings unchanged.
- R3: An accepted configuration write closes the unlock interval at once, so a second write right after it is ignored.
- R4: Once `lock_in` has been high for a cycle, every write is ignored until `rst_n` is asserted. After that reset, writes work again.
- R5: Address 1 holds the control fields: bit 0 is enable, bit 1 selects window mode (1 = window), and bits 5:2 hold the period code. Period code p selects 8·2^p ticks for p from 0 to 10. Codes 11 to 15 select 8192 ticks. When enabled with no restart, `rst_req` is high in the cycle after the tick that completes the period.
- R6: In normal mode, a restart at any count clears the counter, so a full new period must elapse before a timeout.
- R7: Address 2 bits 3:0 hold the window code, which uses the same tick encoding as the period code. In window mode, a restart while fewer than the window's tick count have elapsed raises `rst_req` in the next cycle. A restart at or after that count clears the counter without a request.
- R8: If the window's tick count is greater than or equal to the period's tick count, early restarts are not checked.
- R9: `rst_req` lasts exactly one cycle. The counter restarts from zero after it, and any tick or restart sampled during that cycle is ignored.
- R10: While disabled, the counter stays at zero, ticks and restarts have no effect, and `rst_req` stays low.
- R11: An accepted write to address 1 clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per 1 kHz timebase period |
| restart | input | 1 | One-cycle software restart strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 key, 1 control, 2 window |
| wr_data | input | 8 | Write data |
| lock_in | input | 1 | Sticky configuration lock |
| rst_req | output | 1 | One-cycle system reset request |
| cfg_en | output | 1 | Current enable setting |
| cfg_win_mode | output | 1 | Current mode, 1 = window |
| cfg_period | output | 4 | Current period code |
| cfg_window | output | 4 | Current window code |

## Verification
The assertions run on every cycle and check four things. A request lasts a single cycle and only ever follows a tick or a restart while the watchdog is enabled. Settings never change while locked. Settings only change within a few cycles of a key write. Exact tick counts cannot be checked that way, so the bench scenarios cover them. These include the threshold for each period code, the boundary between the closed and open window, restarts that fall inside a request cycle, and counter clears caused by writes.

// File: rtl/win_wdt.sv
module win_wdt #(
  parameter int          DATA_W        = 8,
  parameter int          CODE_W        = 4,
  parameter logic [7:0]  KEY           = 8'hD8,
  parameter int          UNLOCK_CYCLES = 4,
  parameter int          NUM_CODES     = 11,
  parameter int          BASE_LOG2     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock_in,
  output logic              rst_req,
  output logic              cfg_en,
  output logic              cfg_win_mode,
  output logic [CODE_W-1:0] cfg_period,
  output logic [CODE_W-1:0] cfg_window
);

  localparam int CW = BASE_LOG2 + NUM_CODES - 1;
  localparam int UW = $clog2(UNLOCK_CYCLES + 1);
  localparam logic [1:0] A_KEY  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_WIN  = 2'd2;

  function automatic logic [CW:0] code_ticks(input logic [CODE_W-1:0] c);
    if (int'(c) >= NUM_CODES) return (CW+1)'(1) << CW;
    return (CW+1)'(1) << (BASE_LOG2 + int'(c));
  endfunction

  logic          locked_q;
  logic [UW-1:0] unl_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, mode_q, req_q;
  logic [CODE_W-1:0] per_q, win_q;

  wire locked  = locked_q | lock_in;
  wire key_hit = wr_en && !locked && wr_addr == A_KEY && wr_data == DATA_W'(KEY);
  wire cfg_ok  = wr_en && !locked && unl_q != '0 && (wr_addr == A_CTRL || wr_addr == A_WIN);
  wire ctrl_wr = cfg_ok && wr_addr == A_CTRL;
  wire win_wr  = cfg_ok && wr_addr == A_WIN;

  wire [CW:0] per_ticks = code_ticks(per_q);
  wire [CW:0] win_ticks = code_ticks(win_q);
  wire [CW:0] cnt_x     = {1'b0, cnt_q};

  wire active = en_q && !req_q;
  wire early  = active && restart && mode_q && (win_ticks < per_ticks) && (cnt_x < win_ticks);
  wire late   = active && !restart && tick && (cnt_x >= per_ticks - (CW+1)'(1));
  wire fire   = early || late;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      unl_q    <= '0;
    end else begin
      if (lock_in) locked_q <= 1'b1;
      if (key_hit)          unl_q <= UW'(UNLOCK_CYCLES);
      else if (cfg_ok)      unl_q <= '0;
      else if (unl_q != '0) unl_q <= unl_q - UW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      per_q  <= '0;
      win_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wr_data[0];
        mode_q <= wr_data[1];
        per_q  <= wr_data[2 +: CODE_W];
      end
      if (win_wr) win_q <= wr_data[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= fire;
      if (!active || ctrl_wr || fire || restart) cnt_q <= '0;
      else if (tick)                             cnt_q <= cnt_q + CW'(1);
    end
  end

  assign rst_req      = req_q;
  assign cfg_en       = en_q;
  assign cfg_win_mode = mode_q;
  assign cfg_period   = per_q;
  assign cfg_window   = win_q;

endmodule

// File: rtl/win_wdt_chk.sv
module win_wdt_chk #(
  parameter int         DATA_W = 8,
  parameter int         CODE_W = 4,
  parameter logic [7:0] KEY    = 8'hD8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              restart,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              lock_in,
  input logic              rst_req,
  input logic              cfg_en,
  input logic              cfg_win_mode,
  input logic [CODE_W-1:0] cfg_period,
  input logic [CODE_W-1:0] cfg_window
);

  logic       seen_lock;
  logic [2:0] since_key;
  wire [2*CODE_W+1:0] cfg_all = {cfg_en, cfg_win_mode, cfg_period, cfg_window};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_lock <= 1'b0;
      since_key <= 3'd7;
    end else begin
      if (lock_in) seen_lock <= 1'b1;
      if (wr_en && wr_addr == 2'd0 && wr_data == DATA_W'(KEY)) since_key <= 3'd1;
      else if (since_key != 3'd7) since_key <= since_key + 3'd1;
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r10_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(cfg_en));

  a_r5_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(tick || restart));

  a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_in || seen_lock) |=> $stable(cfg_all));

  a_r2_change_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_all) |-> (since_key >= 3'd2 && since_key <= 3'd5));

endmodule

bind win_wdt win_wdt_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .lock_in(lock_in), .rst_req(rst_req),
  .cfg_en(cfg_en), .cfg_win_mode(cfg_win_mode), .cfg_period(cfg_period),
  .cfg_window(cfg_window)
);

// File: tb/win_wdt_tb.sv
module win_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam logic [3:0] V_CODE [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6,
                                         4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd15};
  localparam int V_EXP [NV] = '{8, 16, 32, 64, 128, 256, 512, 1024, 2048, 4096,
                                8192, 8192, 8192};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, restart = 1'b0, wr_en = 1'b0, lock_in = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rst_req, cfg_en, cfg_win_mode;
  logic [3:0] cfg_period, cfg_window;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .lock_in(lock_in), .rst_req(rst_req),
    .cfg_en(cfg_en), .cfg_win_mode(cfg_win_mode), .cfg_period(cfg_period),
    .cfg_window(cfg_window)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input logic [3:0] code, input bit mode, input bit en);
    wr(2'd0, 8'hD8);
    wr(2'd1, {2'b00, code, mode, en});
  endtask

  task automatic set_win(input logic [3:0] code);
    wr(2'd0, 8'hD8);
    wr(2'd2, {4'h0, code});
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic run_ticks(input int n, output int first);
    first = 0;
    for (int i = 1; i <= n; i++) begin
      do_tick();
      if (rst_req && first == 0) first = i;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rst_req == 0, "R1 rst_req", rst_req, 0);
    chk({cfg_en, cfg_win_mode, cfg_period, cfg_window} == 0, "R1 cfg",
        {cfg_en, cfg_win_mode, cfg_period, cfg_window}, 0);

    // R2 write without key, wrong key, late write, write on last open cycle
    wr(2'd1, 8'h07);
    chk(cfg_en == 0, "R2 no key", cfg_en, 0);
    wr(2'd0, 8'hD7); wr(2'd1, 8'h07);
    chk(cfg_en == 0, "R2 wrong key", cfg_en, 0);
    wr(2'd0, 8'hD8); repeat (4) @(negedge clk); wr(2'd2, 8'h03);
    chk(cfg_window == 0, "R2 late write", cfg_window, 0);
    wr(2'd0, 8'hD8); repeat (3) @(negedge clk); wr(2'd2, 8'h03);
    chk(cfg_window == 3, "R2 fourth cycle", cfg_window, 3);

    // R3 window closes after one accepted write
    wr(2'd0, 8'hD8); wr(2'd2, 8'h00); wr(2'd2, 8'h05);
    chk(cfg_window == 0, "R3 second write", cfg_window, 0);

    // R5 table of period codes, normal mode
    for (int v = 0; v < NV; v++) begin
      set_ctrl(V_CODE[v], 1'b0, 1'b1);
      run_ticks(V_EXP[v], f);
      chk(f == V_EXP[v], "R5 timeout ticks", f, V_EXP[v]);
      @(negedge clk);
    end

    // R6 restart in normal mode
    set_ctrl(4'd0, 1'b0, 1'b1);
    run_ticks(7, f);
    chk(f == 0, "R6 before restart", f, 0);
    do_restart();
    chk(rst_req == 0, "R6 restart no req", rst_req, 0);
    run_ticks(8, f);
    chk(f == 8, "R6 full period after restart", f, 8);
    @(negedge clk);

    // R9 pulse width and ignored tick during request
    set_ctrl(4'd0, 1'b0, 1'b1);
    run_ticks(8, f);
    chk(f == 8, "R9 fire", f, 8);
    do_tick();
    chk(rst_req == 0, "R9 single cycle", rst_req, 0);
    run_ticks(8, f);
    chk(f == 8, "R9 tick in req cycle ignored", f, 8);
    @(negedge clk);

    // R7 window mode: period 16, window 8
    set_win(4'd0);
    set_ctrl(4'd1, 1'b1, 1'b1);
    run_ticks(3, f);
    do_restart();
    chk(rst_req == 1, "R7 early restart", rst_req, 1);
    @(negedge clk);
    run_ticks(7, f);
    do_restart();
    chk(rst_req == 1, "R7 restart at 7", rst_req, 1);
    @(negedge clk);
    run_ticks(8, f);
    do_restart();
    chk(rst_req == 0, "R7 restart at 8 open", rst_req, 0);
    run_ticks(16, f);
    chk(f == 16, "R7 timeout after open restart", f, 16);
    @(negedge clk);

    // R8 window equal to period disables early check
    set_win(4'd1);
    set_ctrl(4'd1, 1'b1, 1'b1);
    run_ticks(2, f);
    do_restart();
    chk(rst_req == 0, "R8 no early check", rst_req, 0);

    // R10 disabled
    set_ctrl(4'd0, 1'b0, 1'b0);
    run_ticks(10, f);
    chk(f == 0, "R10 no timeout", f, 0);
    do_restart();
    chk(rst_req == 0, "R10 restart ignored", rst_req, 0);
    set_ctrl(4'd0, 1'b0, 1'b1);
    run_ticks(8, f);
    chk(f == 8, "R10 counter held at zero", f, 8);
    @(negedge clk);

    // R11 control write clears counter
    set_ctrl(4'd0, 1'b0, 1'b1);
    run_ticks(5, f);
    set_ctrl(4'd0, 1'b0, 1'b1);
    run_ticks(8, f);
    chk(f == 8, "R11 clear on write", f, 8);
    @(negedge clk);

    // R4 lock
    set_ctrl(4'd2, 1'b0, 1'b0);
    lock_in = 1'b1; @(negedge clk); lock_in = 1'b0;
    set_ctrl(4'd5, 1'b1, 1'b1);
    chk(cfg_period == 2 && cfg_en == 0, "R4 locked", cfg_period, 2);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    set_ctrl(4'd5, 1'b0, 1'b0);
    chk(cfg_period == 5, "R4 released by reset", cfg_period, 5);

    done = 1;
    finish_run();
  end
endmodule